// File: doc/BRIEF.md
# Serial NOR Flash Quad-Enable and Chip-Erase Sequencer

This block is a hardware sequencer that prepares an external serial NOR flash and then wipes it, with no software in the loop. A single start pulse launches a fixed flow over a one-lane SPI master port. First, a write-enable frame unlocks the device, and a register-write frame sets the quad bit in the configuration register. Then the status register is polled until the write completes. Next, a second write-enable frame unlocks the device again, a whole-chip erase command is sent, and the status register is polled once more.

The sequencer drives chip select, the serial clock and MOSI, and samples MISO. Every command goes out as its own chip-select frame, and chip select stays high for a programmable number of clocks between frames. A status frame stays open while status bytes are clocked in, one after another, until the write-in-progress bit reads zero. A programmable limit on status bytes guards against a device that never finishes. The host sees a busy level, a one-cycle done pulse, and an error flag.

Top module: `qspi_erase_seq`

## Requirements
- R1: While reset is applied and right after it is released, spi_cs_n_o is 1, spi_sck_o is 0, and busy_o, done_o and err_o are 0.
- R2: A start pulse in idle produces exactly six chip-select frames in this order: {06h}, {01h, 00h, 02h}, {05h, status bytes}, {06h}, {C7h}, {05h, status bytes}.
- R3: Every frame whose first byte is 01h or C7h comes directly after a frame that consists of the single byte 06h.
- R4: Between the end of one frame and the start of the next, spi_cs_n_o stays high for at least CS_GAP clock cycles.
- R5: The serial link uses SPI mode 0, MSB first. spi_sck_o idles low. MOSI changes only on a falling SCK edge, or before the first rising edge of a byte. MISO is sampled on the rising SCK edge. Each SCK half period lasts CLK_DIV clock cycles.
- R6: In a status frame the sequencer sends 05h and then 00h for every further byte. It keeps clocking status bytes until one arrives with bit 0 equal to 0, and it closes the frame after that byte.
- R7: If POLL_LIMIT status bytes in a row inside one status frame all have bit 0 set, the frame closes and err_o goes to 1. err_o stays at 1 until the next start is accepted. No further frame is sent, and done_o stays 0. POLL_LIMIT-1 busy bytes followed by an idle byte complete normally.
- R8: After the last status frame closes without error, done_o is high for exactly one cycle, and busy_o falls in that same cycle.
- R9: A start pulse while busy_o is 1 has no effect on the frame sequence or on the number of done pulses.
- R10: While busy_o is 0, spi_cs_n_o stays high and no SCK edges occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Pulse that launches the flow when idle |
| busy_o | output | 1 | High while the flow runs |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Poll-limit error flag, cleared by the next accepted start |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | Serial clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with CLK_DIV=2, CS_GAP=3 and POLL_LIMIT=4. With these values a whole flow takes only a few hundred cycles, so many scenarios fit in one run. A limit of four status bytes puts both sides of the timeout boundary within easy reach: three busy bytes then success, and four busy bytes then error, in either of the two polls. A flash model in the bench answers with a chosen number of busy status bytes. It also tracks its own write-enable latch, which catches writes that arrive without being unlocked first.

// File: rtl/qes_pkg.sv
`timescale 1ns/1ps
package qes_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRREG = 8'h01;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_CHIPE = 8'hC7;
  localparam logic [7:0] VAL_SR1  = 8'h00;
  localparam logic [7:0] VAL_CFG  = 8'h02;
  localparam logic [7:0] FILLER   = 8'h00;

  typedef enum logic [2:0] {
    STEP_WREN_A, STEP_SETCFG, STEP_POLL_A,
    STEP_WREN_B, STEP_ERASE, STEP_POLL_B
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_GAP, ST_XFER
  } state_e;
endpackage

// File: rtl/qes_byte_shifter.sv
`timescale 1ns/1ps
// Moves one byte over the mode-0 link. The byte goes out MSB first. The last
// bit sampled from MISO is bit 0 of the received byte, and that bit is all
// the sequencer needs.
module qes_byte_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_byte_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic       rx_lsb_o
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          active_q, active_d;
  logic          sck_q, sck_d;
  logic [DW-1:0] div_q, div_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          done_q, done_d;
  logic          rx_q, rx_d;
  logic          en;

  always_comb begin
    active_d = active_q;
    sck_d    = sck_q;
    div_d    = div_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    if (go_i && !active_q) begin
      active_d = 1'b1;
      sck_d    = 1'b0;
      div_d    = '0;
      bit_d    = '0;
      sh_d     = tx_byte_i;
    end else if (active_q) begin
      if (div_q == DIV_LAST) begin
        div_d = '0;
        sck_d = !sck_q;
        if (!sck_q) begin
          rx_d = miso_i;
        end else if (bit_q == 3'd7) begin
          active_d = 1'b0;
          done_d   = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          sh_d  = {sh_q[6:0], 1'b0};
        end
      end else begin
        div_d = div_q + DW'(1);
      end
    end
  end

  assign en = active_q || go_i || done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      done_q   <= 1'b0;
      rx_q     <= 1'b0;
    end else if (en) begin
      active_q <= active_d;
      sck_q    <= sck_d;
      div_q    <= div_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      done_q   <= done_d;
      rx_q     <= rx_d;
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = sh_q[7];
  assign done_o   = done_q;
  assign rx_lsb_o = rx_q;
endmodule

// File: rtl/qes_seq_ctrl.sv
`timescale 1ns/1ps
module qes_seq_ctrl
  import qes_pkg::*;
#(
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       byte_done_i,
  input  logic       rx_lsb_i,
  output logic       go_o,
  output logic [7:0] tx_byte_o,
  output logic       cs_n_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int GW = $clog2(CS_GAP + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(CS_GAP - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

  state_e        state_q, state_d;
  step_e         step_q, step_d;
  logic [1:0]    idx_q, idx_d;
  logic [GW-1:0] gap_q, gap_d;
  logic [PW-1:0] poll_q, poll_d;
  logic          cs_n_q, cs_n_d;
  logic          go_q, go_d;
  logic [7:0]    tx_q, tx_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          is_poll, close_frame;

  function automatic logic [7:0] pick_byte(step_e s, logic [1:0] i);
    case (s)
      STEP_SETCFG: pick_byte = (i == 2'd0) ? OP_WRREG : (i == 2'd1) ? VAL_SR1 : VAL_CFG;
      STEP_POLL_A,
      STEP_POLL_B: pick_byte = (i == 2'd0) ? OP_RDSR : FILLER;
      STEP_ERASE:  pick_byte = OP_CHIPE;
      default:     pick_byte = OP_WREN;
    endcase
  endfunction

  function automatic step_e next_step(step_e s);
    case (s)
      STEP_WREN_A: next_step = STEP_SETCFG;
      STEP_SETCFG: next_step = STEP_POLL_A;
      STEP_POLL_A: next_step = STEP_WREN_B;
      STEP_WREN_B: next_step = STEP_ERASE;
      default:     next_step = STEP_POLL_B;
    endcase
  endfunction

  assign is_poll = (step_q == STEP_POLL_A) || (step_q == STEP_POLL_B);

  always_comb begin
    state_d     = state_q;
    step_d      = step_q;
    idx_d       = idx_q;
    gap_d       = gap_q;
    poll_d      = poll_q;
    cs_n_d      = cs_n_q;
    err_d       = err_q;
    go_d        = 1'b0;
    done_d      = 1'b0;
    close_frame = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_GAP;
          step_d  = STEP_WREN_A;
          gap_d   = '0;
          err_d   = 1'b0;
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_LAST) begin
          state_d = ST_XFER;
          idx_d   = '0;
          poll_d  = '0;
          cs_n_d  = 1'b0;
          go_d    = 1'b1;
        end else begin
          gap_d = gap_q + GW'(1);
        end
      end
      ST_XFER: begin
        if (byte_done_i) begin
          if (is_poll) begin
            if (idx_q == 2'd0) begin
              idx_d = 2'd1;
              go_d  = 1'b1;
            end else if (!rx_lsb_i) begin
              close_frame = 1'b1;
            end else if (poll_q == POLL_LAST) begin
              cs_n_d  = 1'b1;
              err_d   = 1'b1;
              state_d = ST_IDLE;
            end else begin
              poll_d = poll_q + PW'(1);
              go_d   = 1'b1;
            end
          end else if ((step_q == STEP_SETCFG) ? (idx_q == 2'd2) : 1'b1) begin
            close_frame = 1'b1;
          end else begin
            idx_d = idx_q + 2'd1;
            go_d  = 1'b1;
          end
          if (close_frame) begin
            cs_n_d = 1'b1;
            if (step_q == STEP_POLL_B) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              step_d  = next_step(step_q);
              gap_d   = '0;
              state_d = ST_GAP;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    tx_d = go_d ? pick_byte(step_d, idx_d) : tx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= STEP_WREN_A;
      idx_q   <= '0;
      gap_q   <= '0;
      poll_q  <= '0;
      cs_n_q  <= 1'b1;
      go_q    <= 1'b0;
      tx_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      idx_q   <= idx_d;
      gap_q   <= gap_d;
      poll_q  <= poll_d;
      cs_n_q  <= cs_n_d;
      go_q    <= go_d;
      tx_q    <= tx_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign go_o      = go_q;
  assign tx_byte_o = tx_q;
  assign cs_n_o    = cs_n_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/qspi_erase_seq.sv
`timescale 1ns/1ps
module qspi_erase_seq #(
  parameter int CLK_DIV    = 2,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic spi_cs_n_o,
  output logic spi_sck_o,
  output logic spi_mosi_o,
  input  logic spi_miso_i
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       go, byte_done, rx_lsb;
  logic [7:0] tx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  qes_seq_ctrl #(.CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) u_ctrl (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .start_i     (start_i),
    .byte_done_i (byte_done),
    .rx_lsb_i    (rx_lsb),
    .go_o        (go),
    .tx_byte_o   (tx_byte),
    .cs_n_o      (spi_cs_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  qes_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .go_i      (go),
    .tx_byte_i (tx_byte),
    .miso_i    (spi_miso_i),
    .sck_o     (spi_sck_o),
    .mosi_o    (spi_mosi_o),
    .done_o    (byte_done),
    .rx_lsb_o  (rx_lsb)
  );
endmodule

// File: rtl/qes_checker.sv
`timescale 1ns/1ps
module qes_checker #(
  parameter int CS_GAP = 4
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic spi_cs_n_o,
  input logic spi_sck_o,
  input logic spi_mosi_o
);
  logic [15:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hi_cnt_q <= 16'hFFFF;
    else if (!spi_cs_n_o)         hi_cnt_q <= '0;
    else if (hi_cnt_q != 16'hFFFF) hi_cnt_q <= hi_cnt_q + 16'd1;
  end

  a_r4_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n_o) |-> (hi_cnt_q >= 16'(CS_GAP)));

  a_r5_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck_o) |-> $stable(spi_mosi_o));

  a_r5_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sck_o);

  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r7_err_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !done_o);

  a_r10_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> spi_cs_n_o);
endmodule

bind qspi_erase_seq qes_checker #(.CS_GAP(CS_GAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .spi_cs_n_o (spi_cs_n_o),
  .spi_sck_o  (spi_sck_o),
  .spi_mosi_o (spi_mosi_o)
);

// File: tb/qspi_erase_seq_tb.sv
`timescale 1ns/1ps
module qspi_erase_seq_tb;
  localparam int CLK_DIV = 2;
  localparam int CS_GAP  = 3;
  localparam int PLIM    = 4;
  localparam int NVEC    = 5;
  // busy bytes in poll A, busy bytes in poll B, expected frames, expected error
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 6, 0},
    '{4, 0, 3, 1},
    '{2, 3, 6, 0},
    '{1, 4, 6, 1},
    '{3, 3, 6, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, err, cs_n, sck, mosi;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  qspi_erase_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(PLIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .err_o(err), .spi_cs_n_o(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi),
    .spi_miso_i(miso)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // flash model / monitor state
  int frames, cur, bitc, poll_no, busy_left, b_a, b_b;
  int flen [16];
  logic [7:0] fb [16][4];
  logic [7:0] shin, sout;
  int gap_bad, per_bad, fill_bad, wel_bad, done_cnt, last_rise, last_cs_hi;
  logic wel;

  always @(negedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (done) done_cnt++;

  always @(negedge cs_n) begin
    if (last_cs_hi >= 0 && (cyc - last_cs_hi) < CS_GAP) gap_bad++;
    cur = frames;
    frames++;
    bitc = 0;
    last_rise = -1;
    if (cur < 16) begin
      flen[cur] = 0;
      for (int k = 0; k < 4; k++) fb[cur][k] = 8'hxx;
    end
  end

  always @(posedge cs_n) begin
    last_cs_hi = cyc;
    if (cur < 16) begin
      if (fb[cur][0] == 8'h06 && flen[cur] == 1) wel = 1'b1;
      else if (fb[cur][0] == 8'h01 || fb[cur][0] == 8'hC7) begin
        if (!wel) wel_bad++;
        wel = 1'b0;
      end
    end
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      if (last_rise >= 0 && (bitc % 8) != 0 && (cyc - last_rise) != 2 * CLK_DIV) per_bad++;
      last_rise = cyc;
      shin = {shin[6:0], mosi};
      bitc++;
      if (bitc % 8 == 0 && cur < 16) begin
        if (bitc / 8 - 1 < 4) fb[cur][bitc / 8 - 1] = shin;
        flen[cur] = bitc / 8;
        if (bitc == 8 && shin == 8'h05) begin
          busy_left = (poll_no == 0) ? b_a : b_b;
          poll_no++;
        end
        if (bitc > 8 && fb[cur][0] == 8'h05 && shin != 8'h00) fill_bad++;
      end
    end
  end

  always @(negedge sck) begin
    if (!cs_n) begin
      if (bitc % 8 == 0) begin
        if (cur < 16 && fb[cur][0] == 8'h05) begin
          sout = (busy_left > 0) ? 8'h03 : 8'h00;
          if (busy_left > 0) busy_left--;
        end else sout = 8'hFF;
      end else sout = {sout[6:0], 1'b0};
      miso = sout[7];
    end
  end

  task automatic clear_model(input int a, input int b);
    frames = 0; cur = 0; poll_no = 0; busy_left = 0; b_a = a; b_b = b;
    gap_bad = 0; per_bad = 0; fill_bad = 0; wel_bad = 0; done_cnt = 0;
    last_cs_hi = -1; wel = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_vec(input int a, input int b, input int xf, input int xe, input bit mid);
    int guard;
    clear_model(a, b);
    pulse_start();
    chk(err == 1'b0, "R7 err cleared by start", int'(err), 0);
    chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (mid && guard == 100) begin
        start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
    end
    repeat (2) @(negedge clk);
    chk(frames == xf, "R2 frame count", frames, xf);
    chk(fb[0][0] == 8'h06 && flen[0] == 1, "R2 frame0 write-enable", int'(fb[0][0]), 6);
    chk(fb[1][0] == 8'h01 && fb[1][1] == 8'h00 && fb[1][2] == 8'h02 && flen[1] == 3,
        "R2 frame1 config write", int'(fb[1][2]), 2);
    chk(fb[2][0] == 8'h05, "R2 frame2 status read", int'(fb[2][0]), 5);
    chk(flen[2] == 1 + ((a + 1 < PLIM) ? a + 1 : PLIM), "R6 poll A length", flen[2],
        1 + ((a + 1 < PLIM) ? a + 1 : PLIM));
    if (xf == 6) begin
      chk(fb[3][0] == 8'h06 && flen[3] == 1, "R2 frame3 write-enable", int'(fb[3][0]), 6);
      chk(fb[4][0] == 8'hC7 && flen[4] == 1, "R2 frame4 chip erase", int'(fb[4][0]), 199);
      chk(fb[5][0] == 8'h05, "R2 frame5 status read", int'(fb[5][0]), 5);
      chk(flen[5] == 1 + ((b + 1 < PLIM) ? b + 1 : PLIM), "R6 poll B length", flen[5],
          1 + ((b + 1 < PLIM) ? b + 1 : PLIM));
    end
    chk(fill_bad == 0, "R6 filler bytes zero", fill_bad, 0);
    chk(wel_bad == 0, "R3 write-enable gating", wel_bad, 0);
    chk(gap_bad == 0, "R4 chip-select gap", gap_bad, 0);
    chk(per_bad == 0, "R5 sck half period", per_bad, 0);
    chk(int'(err) == xe, "R7 error flag", int'(err), xe);
    chk(done_cnt == (xe ? 0 : 1), "R8 done pulse count", done_cnt, xe ? 0 : 1);
    chk(cs_n == 1'b1 && sck == 1'b0, "R10 idle lines", int'(cs_n), 1);
  endtask

  initial begin
    int f0;
    clear_model(0, 0);
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 reset lines", int'(cs_n), 1);
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 reset status",
        int'({busy, done, err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && cs_n == 1'b1 && err == 1'b0, "R1 after release",
        int'({busy, cs_n, err}), 2);

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], v == 2);

    // R7: error persists while idle, then a clean run clears it
    clear_model(PLIM, 0);
    run_vec(PLIM, 0, 3, 1, 1'b0);
    repeat (20) @(negedge clk);
    chk(err == 1'b1, "R7 error held while idle", int'(err), 1);
    run_vec(0, PLIM - 1, 6, 0, 1'b0);

    // R10: idle for a while, no frame activity
    f0 = frames;
    repeat (300) @(negedge clk);
    chk(frames == f0 && cs_n == 1'b1, "R10 no activity while idle", frames, f0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule